// File: doc/BRIEF.md
# 8-bit ALU with Status-Word Flags

This block is the purely combinational arithmetic and logic stage of a small accumulator-based microcontroller core. The caller presents a 4-bit operation code, two 8-bit operands and the current 8-bit processor status word. In the same cycle the block returns an 8-bit result, an updated status word, and a store-enable output. The store-enable output says whether the result is to be written back. Compare and clear-overflow affect only the flags, so they deassert it.

Subtraction and compare share the adder: the second operand is inverted, and the carry-in acts as "no borrow". A half-carry flag comes from the carry out of bit 3. The status word also carries a page-select bit, a break bit and an interrupt-enable bit. The block passes these three bits through untouched.

The block has no clock and no states. The operation code alone selects one of four data paths: the shared adder, the bitwise and counting unit, the shift unit, or flag-only handling. The flags are then assembled from the selected path.

Top module: `alu8_core`

## Requirements
- R1: Status word bit positions are N=7, V=6, P=5, B=4, H=3, I=2, Z=1, C=0. Operation codes are ADC=0, SBC=1, CMP=2, AND=3, OR=4, XOR=5, INC=6, DEC=7, LSR=8, ASL=9, ROR=10, ROL=11, SWAP=12, CLRV=13.
- R2: ADC produces a + b + C. It sets C from the carry out of bit 7, H from the carry out of bit 3, V on signed 8-bit overflow, N from result bit 7, and Z when the result is zero. Store-enable is 1.
- R3: SBC produces a + (~b) + C with the same flag rules as ADC, so C=1 after SBC means no borrow occurred.
- R4: CMP evaluates a - b and updates only N, Z and C, with C=1 when a >= b (unsigned). V and H keep their input values, the result output equals a, and store-enable is 0.
- R5: AND, OR and XOR combine a with b bitwise and update only N and Z. C, V and H are unchanged, and store-enable is 1.
- R6: INC and DEC add +1 or -1 to a with 8-bit wrap and update only N and Z. C, V and H are unchanged, and store-enable is 1.
- R7: LSR and ASL shift a by one bit (right and left respectively) with a zero shifted in. The bit shifted out becomes C, N and Z follow the result, and V and H are unchanged.
- R8: ROR and ROL shift a by one bit with the input C shifted in. The bit shifted out becomes C.
- R9: SWAP exchanges the upper and lower nibbles of a and updates only N and Z.
- R10: CLRV clears V and H, leaves every other status bit unchanged, outputs a as the result, and deasserts store-enable.
- R11: No operation changes the P, B or I bits.
- R12: Codes 14 and 15 output a as the result and leave the status word unchanged, with store-enable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see R1) |
| opnd_a | input | 8 | First operand, the register side |
| opnd_b | input | 8 | Second operand |
| psw_in | input | 8 | Current processor status word |
| result_o | output | 8 | Operation result |
| psw_o | output | 8 | Updated processor status word |
| wr_en_o | output | 1 | Result is to be stored |

## Verification
The block holds no state, so any fault shows up at the ports in the same evaluation as the inputs that expose it. It has no latency to hide behind. A wrong carry-in polarity in the shared adder shows up on borrow and equal-compare cases as a wrong C or an off-by-one result. A wrong nibble boundary shows up as a wrong H. A flag path enabled for the wrong operation shows up as a corrupted C, V or H on logic, count or compare operations. A faulty pass-through shows up as changed P, B or I bits, or as a store-enable asserted on compare, clear-overflow or the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int PSW_W = 8;

    // status word bit positions
    localparam int F_N = 7;
    localparam int F_V = 6;
    localparam int F_P = 5;
    localparam int F_B = 4;
    localparam int F_H = 3;
    localparam int F_I = 2;
    localparam int F_Z = 1;
    localparam int F_C = 0;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ASL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_SWAP = 4'd12,
        OP_CLRV = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              invert_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   low_sum;

    always_comb begin
        b_eff    = invert_i ? ~b_i : b_i;
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + (DATA_W+1)'(cin_i);
        low_sum  = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                   + (HALF_W+1)'(cin_i);
        sum_o    = full_sum[DATA_W-1:0];
        cout_o   = full_sum[DATA_W];
        half_o   = low_sum[HALF_W];
        ovf_o    = (a_i[DATA_W-1] == b_eff[DATA_W-1])
                && (full_sum[DATA_W-1] != a_i[DATA_W-1]);
    end
endmodule

// File: rtl/alu8_bitunit.sv
module alu8_bitunit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        res_o = a_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_INC:  res_o = a_i + DATA_W'(1);
            OP_DEC:  res_o = a_i - DATA_W'(1);
            OP_SWAP: res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    logic fill;

    always_comb begin
        fill   = (op_i == OP_ROR || op_i == OP_ROL) ? cin_i : 1'b0;
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_LSR, OP_ROR: begin
                res_o  = {fill, a_i[DATA_W-1:1]};
                cout_o = a_i[0];
            end
            OP_ASL, OP_ROL: begin
                res_o  = {a_i[DATA_W-2:0], fill};
                cout_o = a_i[DATA_W-1];
            end
            default: begin
                res_o  = a_i;
                cout_o = cin_i;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [PSW_W-1:0]  psw_in,
    output logic [DATA_W-1:0] result_o,
    output logic [PSW_W-1:0]  psw_o,
    output logic              wr_en_o
);
    alu_op_e           op;
    logic              sub_mode;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_half;
    logic              add_ovf;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] nz_src;
    logic              nz_upd;

    assign op       = alu_op_e'(op_sel);
    assign sub_mode = (op == OP_SBC) || (op == OP_CMP);
    assign add_cin  = (op == OP_CMP) ? 1'b1 : psw_in[F_C];

    alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a_i      (opnd_a),
        .b_i      (opnd_b),
        .invert_i (sub_mode),
        .cin_i    (add_cin),
        .sum_o    (add_sum),
        .cout_o   (add_cout),
        .half_o   (add_half),
        .ovf_o    (add_ovf)
    );

    alu8_bitunit #(.DATA_W(DATA_W)) bitunit_i (
        .op_i  (op),
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .res_o (bit_res)
    );

    alu8_shifter #(.DATA_W(DATA_W)) shifter_i (
        .op_i   (op),
        .a_i    (opnd_a),
        .cin_i  (psw_in[F_C]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    always_comb begin
        result_o = opnd_a;
        psw_o    = psw_in;
        wr_en_o  = 1'b0;
        nz_src   = opnd_a;
        nz_upd   = 1'b0;
        unique case (op)
            OP_ADC, OP_SBC: begin
                result_o   = add_sum;
                psw_o[F_C] = add_cout;
                psw_o[F_H] = add_half;
                psw_o[F_V] = add_ovf;
                wr_en_o    = 1'b1;
                nz_src     = add_sum;
                nz_upd     = 1'b1;
            end
            OP_CMP: begin
                psw_o[F_C] = add_cout;
                nz_src     = add_sum;
                nz_upd     = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_SWAP: begin
                result_o = bit_res;
                wr_en_o  = 1'b1;
                nz_src   = bit_res;
                nz_upd   = 1'b1;
            end
            OP_LSR, OP_ASL, OP_ROR, OP_ROL: begin
                result_o   = sh_res;
                psw_o[F_C] = sh_cout;
                wr_en_o    = 1'b1;
                nz_src     = sh_res;
                nz_upd     = 1'b1;
            end
            OP_CLRV: begin
                psw_o[F_V] = 1'b0;
                psw_o[F_H] = 1'b0;
            end
            default: begin
                result_o = opnd_a;
            end
        endcase
        if (nz_upd) begin
            psw_o[F_N] = nz_src[DATA_W-1];
            psw_o[F_Z] = (nz_src == '0);
        end
    end

    // checks placed beside the flag assembly
    always_comb begin
        // R11
        ctrl_bits_kept_chk: assert (psw_o[F_P] == psw_in[F_P] && psw_o[F_B] == psw_in[F_B]
                                    && psw_o[F_I] == psw_in[F_I])
            else $error("control bits of status word changed");
        if (op == OP_CMP) begin
            // R4
            cmp_no_store_chk: assert (!wr_en_o && result_o == opnd_a
                                      && psw_o[F_V] == psw_in[F_V] && psw_o[F_H] == psw_in[F_H])
                else $error("compare stored a result or touched V/H");
        end
        if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_INC || op == OP_DEC) begin
            // R5
            logic_keeps_cvh_chk: assert (psw_o[F_C] == psw_in[F_C] && psw_o[F_V] == psw_in[F_V]
                                         && psw_o[F_H] == psw_in[F_H])
                else $error("logic/count op touched C, V or H");
        end
        if (op == OP_CLRV) begin
            // R10
            clrv_flags_chk: assert (!psw_o[F_V] && !psw_o[F_H] && !wr_en_o)
                else $error("clear-overflow left V/H set or stored");
        end
        if (op_sel == 4'd14 || op_sel == 4'd15) begin
            // R12
            unused_passthru_chk: assert (psw_o == psw_in && result_o == opnd_a && !wr_en_o)
                else $error("unused code was not a pass-through");
        end
    end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] psw_in = '0;
    logic [7:0] result_o;
    logic [7:0] psw_o;
    logic       wr_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut_i (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .psw_in   (psw_in),
        .result_o (result_o),
        .psw_o    (psw_o),
        .wr_en_o  (wr_en_o)
    );

    task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] psw,
                          input logic [7:0] exp_res, input logic [7:0] exp_psw,
                          input logic exp_we);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; psw_in = psw;
        #2;
        checks++;
        if (result_o !== exp_res || psw_o !== exp_psw || wr_en_o !== exp_we) begin
            errors++;
            $display("FAIL %s op=%0d: res=%h psw=%h we=%b expected res=%h psw=%h we=%b",
                     req, op, result_o, psw_o, wr_en_o, exp_res, exp_psw, exp_we);
        end
    endtask

    // R1: quiescent state after reset, op code 0 (ADC) on zeros gives Z only
    task automatic t_reset_state();
        run_op("R1", 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 1'b1);
    endtask

    task automatic t_adc();
        run_op("R2", 4'd0, 8'h7F, 8'h01, 8'h24, 8'h80, 8'hEC, 1'b1);
        run_op("R2", 4'd0, 8'hFF, 8'h00, 8'h25, 8'h00, 8'h2F, 1'b1);
    endtask

    task automatic t_sbc();
        run_op("R3", 4'd1, 8'h05, 8'h03, 8'h25, 8'h02, 8'h2D, 1'b1);
        run_op("R3", 4'd1, 8'h80, 8'h01, 8'h25, 8'h7F, 8'h65, 1'b1);
        run_op("R3", 4'd1, 8'h00, 8'h00, 8'h24, 8'hFF, 8'hA4, 1'b1);
    endtask

    task automatic t_cmp();
        run_op("R4", 4'd2, 8'h10, 8'h10, 8'h6C, 8'h10, 8'h6F, 1'b0);
        run_op("R4", 4'd2, 8'h01, 8'h02, 8'h25, 8'h01, 8'hA4, 1'b0);
    endtask

    task automatic t_logic();
        run_op("R5", 4'd3, 8'hF0, 8'h0F, 8'h6D, 8'h00, 8'h6F, 1'b1);
        run_op("R5", 4'd4, 8'h80, 8'h01, 8'h27, 8'h81, 8'hA5, 1'b1);
        run_op("R5", 4'd5, 8'hAA, 8'hAA, 8'h24, 8'h00, 8'h26, 1'b1);
    endtask

    task automatic t_count();
        run_op("R6", 4'd6, 8'hFF, 8'h00, 8'h25, 8'h00, 8'h27, 1'b1);
        run_op("R6", 4'd7, 8'h00, 8'h00, 8'h24, 8'hFF, 8'hA4, 1'b1);
        run_op("R6", 4'd7, 8'h01, 8'h00, 8'h6C, 8'h00, 8'h6E, 1'b1);
    endtask

    task automatic t_shift();
        run_op("R7", 4'd8, 8'h81, 8'h00, 8'h25, 8'h40, 8'h25, 1'b1);
        run_op("R7", 4'd9, 8'h80, 8'h00, 8'h25, 8'h00, 8'h27, 1'b1);
    endtask

    task automatic t_rotate();
        run_op("R8", 4'd10, 8'h01, 8'h00, 8'h25, 8'h80, 8'hA5, 1'b1);
        run_op("R8", 4'd11, 8'h80, 8'h00, 8'h24, 8'h00, 8'h27, 1'b1);
        run_op("R8", 4'd11, 8'h40, 8'h00, 8'h25, 8'h81, 8'hA4, 1'b1);
    endtask

    task automatic t_swap();
        run_op("R9", 4'd12, 8'h3C, 8'h00, 8'h24, 8'hC3, 8'hA4, 1'b1);
        run_op("R9", 4'd12, 8'h00, 8'h00, 8'h25, 8'h00, 8'h27, 1'b1);
    endtask

    task automatic t_clrv();
        run_op("R10", 4'd13, 8'h12, 8'h34, 8'hFF, 8'h12, 8'hB7, 1'b0);
    endtask

    task automatic t_ctrl_bits();
        // R11: B set, P and I clear, must pass through
        run_op("R11", 4'd0, 8'h01, 8'h01, 8'h10, 8'h02, 8'h10, 1'b1);
        run_op("R11", 4'd9, 8'h01, 8'h00, 8'h34, 8'h02, 8'h34, 1'b1);
    endtask

    task automatic t_unused();
        run_op("R12", 4'd14, 8'h5A, 8'hFF, 8'hC3, 8'h5A, 8'hC3, 1'b0);
        run_op("R12", 4'd15, 8'hA5, 8'h11, 8'h3C, 8'hA5, 8'h3C, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_adc();
        t_sbc();
        t_cmp();
        t_logic();
        t_count();
        t_shift();
        t_rotate();
        t_swap();
        t_clrv();
        t_ctrl_bits();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule